// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a successive-approximation analog-to-digital converter. Software first turns the converter on, then sets a start/busy control bit. From then on, a once-per-conversion-clock enable pulse (`tad_tick`) paces the sequence. The first period after start is a setup period. Each of the next ten periods resolves one result bit, from the most significant down. The block drives the trial code to the DAC, reads back a single comparator bit, and opens the sample-hold switch for the whole conversion.

On the edge that resolves the last bit, all completion effects happen at once. The result is written into a pair of 8-bit registers, the busy bit clears, a sticky interrupt flag sets and the hold switch closes again. If software clears the start bit during a conversion, the conversion is abandoned. The stored result keeps its last completed value, and a fixed two-period recovery wait runs before acquisition resumes.

Top module: `sar_conv_seq`

## Requirements
- R1: A control write with `ctl_on`=1 and `ctl_go`=1, made while the converter is already on and idle, sets `busy` on the next clock edge.
- R2: `hold_open` is 1 from the start edge for as long as `busy` is 1.
- R3: After a start, the first `tad_tick` is setup and the next ten each resolve one bit. `busy` is still 1 after the 10th tick and is 0 after the edge that takes the 11th tick.
- R4: A trial bit is kept when `cmp_in`=1 (input at or above `dac_code`) at that bit's tick, and cleared otherwise. With an ideal comparator, the result therefore equals the input code.
- R5: On the completion edge, the result registers load, `busy` falls, `conv_flag` rises and `hold_open` falls, all together.
- R6: A control write with `ctl_go`=0 or `ctl_on`=0 while `busy` is 1 aborts the conversion. `busy` is 0 on the next edge and `res_hi`/`res_lo` keep their previous values.
- R7: After an abort, `acq_wait` and `hold_open` stay 1 for exactly two `tad_tick`s, then fall on the edge of the second tick. A start request during this wait is ignored.
- R8: A control write that sets `ctl_on` and `ctl_go` together while the converter is off does not start a conversion.
- R9: The justification is taken from `just_left` at completion. With `just_left`=0, `res_hi`={6'b0, r[9:8]} and `res_lo`=r[7:0]. With `just_left`=1, `res_hi`=r[9:2] and `res_lo`={r[1:0], 6'b0}.
- R10: `conv_flag` stays 1 until a `flag_clr` pulse clears it. If completion and `flag_clr` fall in the same cycle, the flag is set.
- R11: A result-register write (`res_sel`=1 high byte, 0 low byte) is ignored while `busy` is 1 and takes effect on the next edge when idle.
- R12: After reset, `busy`, `hold_open`, `acq_wait`, `conv_flag`, `res_hi` and `res_lo` are 0, and the converter is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tad_tick | input | 1 | One-cycle pulse per conversion-clock period |
| ctl_we | input | 1 | Control register write strobe |
| ctl_on | input | 1 | Converter enable value for the control write |
| ctl_go | input | 1 | Start/busy value for the control write |
| just_left | input | 1 | 1 selects left-justified result packing |
| flag_clr | input | 1 | Clears the completion flag |
| res_we | input | 1 | Result register write strobe |
| res_sel | input | 1 | Result write target: 1 high byte, 0 low byte |
| res_wdata | input | 8 | Result write data |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| dac_code | output | 10 | Trial code presented to the DAC |
| hold_open | output | 1 | 1 while the holding capacitor is disconnected |
| busy | output | 1 | Start/busy readback; 1 during a conversion |
| acq_wait | output | 1 | 1 during the post-abort recovery wait |
| conv_flag | output | 1 | Sticky completion interrupt flag |
| res_hi | output | 8 | High result register |
| res_lo | output | 8 | Low result register |

## Verification
The bench drives a comparator model that, at each clock, compares a random input code against `dac_code`. It runs random and extreme codes (0 and 1023) with both justifications, and checks busy between the 10th and 11th tick to catch a sequencer that is one period short or long. It aborts at random points and checks for two faults: a design that lets the partial result leak into the registers, or one that skips or lengthens the two-tick recovery. It also checks that a start during that wait is ignored. Result writes made while busy, a start in the same write that enables the converter, and flag stickiness are each probed at the ports. A wrong design would show a changed byte, a spurious busy, or a flag that dropped on its own.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_BITS  = 2'd2,
      ST_WAIT  = 2'd3
   } seq_state_t;
endpackage

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
   parameter int N = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic         cmp,
   output logic [N-1:0] trial,
   output logic [N-1:0] kept,
   output logic         last
);
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

   logic [IDX_W-1:0] idx_q;
   logic [N-1:0]     trial_q;
   logic [N-1:0]     next_bit;

   // trial code with the bit under test replaced by the comparator decision
   always_comb begin
      kept = trial_q;
      kept[idx_q] = cmp;
   end

   always_comb begin
      next_bit = '0;
      for (int i = 1; i < N; i++) begin
         if (idx_q == IDX_W'(i)) next_bit[i-1] = 1'b1;
      end
   end

   assign last  = (idx_q == '0);
   assign trial = trial_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trial_q <= '0;
         idx_q   <= '0;
      end else if (load) begin
         trial_q <= {1'b1, {(N-1){1'b0}}};
         idx_q   <= IDX_W'(N-1);
      end else if (step) begin
         trial_q <= last ? kept : (kept | next_bit);
         if (!last) idx_q <= idx_q - 1'b1;
      end
   end

   // decided bit follows the comparator sample taken at its tick
   p_bit_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (trial_q[$past(idx_q)] == $past(cmp)));
endmodule

// File: rtl/sar_result_pack.sv
module sar_result_pack #(
   parameter int RES_BITS = 10,
   parameter int REG_W    = 8
) (
   input  logic [RES_BITS-1:0] code,
   input  logic                left,
   output logic [REG_W-1:0]    hi,
   output logic [REG_W-1:0]    lo
);
   localparam int TOT = 2 * REG_W;
   localparam int SH  = TOT - RES_BITS;

   logic [TOT-1:0] rj;
   logic [TOT-1:0] lj;
   logic [TOT-1:0] word;

   for (genvar i = 0; i < TOT; i++) begin : g_lane
      if (i < RES_BITS) begin : g_r_data
         assign rj[i] = code[i];
      end else begin : g_r_zero
         assign rj[i] = 1'b0;
      end
      if (i >= SH) begin : g_l_data
         assign lj[i] = code[i-SH];
      end else begin : g_l_zero
         assign lj[i] = 1'b0;
      end
   end

   assign word = left ? lj : rj;
   assign hi   = word[TOT-1:REG_W];
   assign lo   = word[REG_W-1:0];
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
   import sar_seq_pkg::*;
#(
   parameter int RES_BITS  = 10,
   parameter int REG_W     = 8,
   parameter int WAIT_TADS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tad_tick,
   input  logic                ctl_we,
   input  logic                ctl_on,
   input  logic                ctl_go,
   input  logic                just_left,
   input  logic                flag_clr,
   input  logic                res_we,
   input  logic                res_sel,
   input  logic [REG_W-1:0]    res_wdata,
   input  logic                cmp_in,
   output logic [RES_BITS-1:0] dac_code,
   output logic                hold_open,
   output logic                busy,
   output logic                acq_wait,
   output logic                conv_flag,
   output logic [REG_W-1:0]    res_hi,
   output logic [REG_W-1:0]    res_lo
);
   localparam int WAIT_W = $clog2(WAIT_TADS + 1);

   initial begin
      assert (RES_BITS > REG_W && RES_BITS <= 2 * REG_W)
         else $error("RES_BITS must span both result registers");
      assert (WAIT_TADS >= 1) else $error("WAIT_TADS must be at least 1");
   end

   seq_state_t          state_q, state_d;
   logic                adc_on_q;
   logic [WAIT_W-1:0]   wait_q;
   logic                flag_q;
   logic [REG_W-1:0]    hi_q, lo_q;
   logic                start, abort, step, done;
   logic [RES_BITS-1:0] trial, kept;
   logic                last;
   logic [REG_W-1:0]    pk_hi, pk_lo;

   assign busy      = (state_q == ST_SETUP) || (state_q == ST_BITS);
   assign hold_open = (state_q != ST_IDLE);
   assign acq_wait  = (state_q == ST_WAIT);
   assign conv_flag = flag_q;
   assign res_hi    = hi_q;
   assign res_lo    = lo_q;
   assign dac_code  = trial;

   // a start bit written together with the enable is not honoured
   assign start = ctl_we && ctl_go && ctl_on && adc_on_q && (state_q == ST_IDLE);
   assign abort = ctl_we && (!ctl_go || !ctl_on) && busy;
   assign step  = tad_tick && (state_q == ST_BITS) && !abort;
   assign done  = step && last;

   sar_bit_engine #(.N(RES_BITS)) u_eng (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .step  (step),
      .cmp   (cmp_in),
      .trial (trial),
      .kept  (kept),
      .last  (last)
   );

   sar_result_pack #(.RES_BITS(RES_BITS), .REG_W(REG_W)) u_pack (
      .code (kept),
      .left (just_left),
      .hi   (pk_hi),
      .lo   (pk_lo)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (start) state_d = ST_SETUP;
         ST_SETUP: if (abort) state_d = ST_WAIT;
                   else if (tad_tick) state_d = ST_BITS;
         ST_BITS:  if (abort) state_d = ST_WAIT;
                   else if (done) state_d = ST_IDLE;
         ST_WAIT:  if (tad_tick && wait_q == WAIT_W'(WAIT_TADS - 1)) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         adc_on_q <= 1'b0;
         wait_q   <= '0;
      end else begin
         state_q <= state_d;
         if (ctl_we) adc_on_q <= ctl_on;
         if (abort) wait_q <= '0;
         else if (acq_wait && tad_tick) wait_q <= wait_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q   <= '0;
         lo_q   <= '0;
         flag_q <= 1'b0;
      end else begin
         if (done) begin
            hi_q <= pk_hi;
            lo_q <= pk_lo;
         end else if (res_we && !busy) begin
            if (res_sel) hi_q <= res_wdata;
            else         lo_q <= res_wdata;
         end
         if (done)          flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;
      end
   end

   p_hold_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> hold_open);
   p_start_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(adc_on_q));
   p_done_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!busy && conv_flag && !hold_open));
   p_abort_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> ($stable(res_hi) && $stable(res_lo) && !busy && acq_wait));
   p_wait_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(acq_wait) |-> $past(tad_tick));
   p_wait_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acq_wait |-> (wait_q < WAIT_W'(WAIT_TADS)));
   p_busy_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && res_we && !done) |=> ($stable(res_hi) && $stable(res_lo)));
   p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_flag && !flag_clr) |=> conv_flag);
endmodule

// File: tb/sim_sar_conv_seq.sv
module sim_sar_conv_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tad_tick = 1'b0, ctl_we = 1'b0, ctl_on = 1'b0, ctl_go = 1'b0;
   logic       just_left = 1'b0, flag_clr = 1'b0, res_we = 1'b0, res_sel = 1'b0;
   logic [7:0] res_wdata = 8'h00;
   logic       cmp_in;
   logic [9:0] dac_code;
   logic       hold_open, busy, acq_wait, conv_flag;
   logic [7:0] res_hi, res_lo;
   logic [9:0] vin = 10'd0;
   logic [7:0] e_hi = 8'h00, e_lo = 8'h00;
   int         n_run = 0, n_fail = 0;
   bit         finished = 1'b0;

   always #2 clk = ~clk;

   // ideal comparator standing in for the analog front end
   assign cmp_in = (vin >= dac_code);

   sar_conv_seq u0 (
      .clk(clk), .rst_n(rst_n), .tad_tick(tad_tick), .ctl_we(ctl_we),
      .ctl_on(ctl_on), .ctl_go(ctl_go), .just_left(just_left),
      .flag_clr(flag_clr), .res_we(res_we), .res_sel(res_sel),
      .res_wdata(res_wdata), .cmp_in(cmp_in), .dac_code(dac_code),
      .hold_open(hold_open), .busy(busy), .acq_wait(acq_wait),
      .conv_flag(conv_flag), .res_hi(res_hi), .res_lo(res_lo)
   );

   function automatic logic [7:0] pack_hi(logic [9:0] v, logic left);
      return left ? v[9:2] : {6'b0, v[9:8]};
   endfunction
   function automatic logic [7:0] pack_lo(logic [9:0] v, logic left);
      return left ? {v[1:0], 6'b0} : v[7:0];
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      int gap = $urandom_range(0, 2);
      repeat (gap) @(negedge clk);
      @(negedge clk) tad_tick = 1'b1;
      @(negedge clk) tad_tick = 1'b0;
   endtask

   task automatic ctl_write(logic on, logic go);
      @(negedge clk) begin ctl_we = 1'b1; ctl_on = on; ctl_go = go; end
      @(negedge clk) ctl_we = 1'b0;
   endtask

   task automatic res_write(logic sel, logic [7:0] d);
      @(negedge clk) begin res_we = 1'b1; res_sel = sel; res_wdata = d; end
      @(negedge clk) res_we = 1'b0;
   endtask

   task automatic clear_flag();
      @(negedge clk) flag_clr = 1'b1;
      @(negedge clk) flag_clr = 1'b0;
      check("R10 flag cleared", 32'(conv_flag), 32'd0);
   endtask

   task automatic full_conv(logic [9:0] v, logic left);
      vin = v;
      just_left = left;
      ctl_write(1'b1, 1'b1);
      check("R1 busy after start", 32'(busy), 32'd1);
      check("R2 hold open at start", 32'(hold_open), 32'd1);
      for (int k = 1; k <= 10; k++) begin
         tick();
         if (k == 5) begin
            res_write(1'b1, 8'hA5);
            check("R11 hi write ignored while busy", 32'(res_hi), 32'(e_hi));
            check("R2 hold open mid conversion", 32'(hold_open), 32'd1);
         end
      end
      check("R3 still busy after tenth tick", 32'(busy), 32'd1);
      tick();
      e_hi = pack_hi(v, left);
      e_lo = pack_lo(v, left);
      check("R3 busy clear after eleventh tick", 32'(busy), 32'd0);
      check("R5 flag set at completion", 32'(conv_flag), 32'd1);
      check("R5 hold closed at completion", 32'(hold_open), 32'd0);
      check("R4 R9 result high", 32'(res_hi), 32'(e_hi));
      check("R4 R9 result low", 32'(res_lo), 32'(e_lo));
   endtask

   task automatic abort_conv(int after);
      vin = 10'($urandom_range(0, 1023));
      ctl_write(1'b1, 1'b1);
      for (int k = 0; k < after; k++) tick();
      ctl_write(1'b1, 1'b0);
      check("R6 busy clear after abort", 32'(busy), 32'd0);
      check("R6 result high kept", 32'(res_hi), 32'(e_hi));
      check("R6 result low kept", 32'(res_lo), 32'(e_lo));
      check("R7 recovery wait active", 32'(acq_wait), 32'd1);
      check("R7 hold open in wait", 32'(hold_open), 32'd1);
      ctl_write(1'b1, 1'b1);
      check("R7 start ignored in wait", 32'(busy), 32'd0);
      tick();
      check("R7 wait after first tick", 32'(acq_wait), 32'd1);
      tick();
      check("R7 wait ends after second tick", 32'(acq_wait), 32'd0);
      check("R7 hold closed after wait", 32'(hold_open), 32'd0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R12 busy reset", 32'(busy), 32'd0);
      check("R12 hold reset", 32'(hold_open), 32'd0);
      check("R12 wait reset", 32'(acq_wait), 32'd0);
      check("R12 flag reset", 32'(conv_flag), 32'd0);
      check("R12 result reset", 32'({res_hi, res_lo}), 32'd0);
      @(negedge clk) rst_n = 1'b1;

      // R8: enable and start in the same write
      ctl_write(1'b1, 1'b1);
      check("R8 no start with enable", 32'(busy), 32'd0);
      tick();
      check("R8 still idle", 32'(busy), 32'd0);

      full_conv(10'd0, 1'b0);
      clear_flag();
      full_conv(10'd1023, 1'b0);
      repeat (5) @(negedge clk);
      check("R10 flag sticky", 32'(conv_flag), 32'd1);
      full_conv(10'd1023, 1'b1);
      full_conv(10'h2C7, 1'b1);
      clear_flag();

      // R10: completion and clear in the same cycle
      vin = 10'h155; just_left = 1'b0;
      ctl_write(1'b1, 1'b1);
      repeat (10) tick();
      @(negedge clk) begin tad_tick = 1'b1; flag_clr = 1'b1; end
      @(negedge clk) begin tad_tick = 1'b0; flag_clr = 1'b0; end
      e_hi = pack_hi(10'h155, 1'b0);
      e_lo = pack_lo(10'h155, 1'b0);
      check("R10 completion wins over clear", 32'(conv_flag), 32'd1);
      check("R4 result low", 32'(res_lo), 32'(e_lo));

      // R11: idle writes land
      res_write(1'b0, 8'h3C); e_lo = 8'h3C;
      check("R11 idle low write", 32'(res_lo), 32'(e_lo));
      res_write(1'b1, 8'hC3); e_hi = 8'hC3;
      check("R11 idle high write", 32'(res_hi), 32'(e_hi));

      abort_conv(0);
      abort_conv(11 - 1);
      // R6: disabling the converter also aborts
      vin = 10'd77;
      ctl_write(1'b1, 1'b1);
      tick(); tick();
      ctl_write(1'b0, 1'b0);
      check("R6 off aborts", 32'(busy), 32'd0);
      check("R6 result kept on off", 32'({res_hi, res_lo}), 32'({e_hi, e_lo}));
      tick(); tick();
      ctl_write(1'b1, 1'b0);

      for (int it = 0; it < 14; it++) begin
         if ($urandom_range(0, 2) == 0) abort_conv($urandom_range(1, 9));
         else full_conv(10'($urandom_range(0, 1023)), 1'($urandom_range(0, 1)));
      end
      clear_flag();

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule